// File: doc/BRIEF.md
# Twin-Predicated Vector Move Unit

This unit moves elements from one register range to another while two separate predicate masks decide which elements take part. The source mask picks the elements that are read and the destination mask picks the slots that are written. The k-th selected source element always lands in the k-th selected destination slot. The effect is the same as packing the selected source elements together and then spreading them out over the selected destination slots. Either side may instead be marked scalar. A scalar side uses its base register at every step.

A controller pulses `start_i` with both base registers, the vector length, both masks and both scalar flags. The range of every vector side is checked on that cycle. If the range is bad, the unit reports a trap and does nothing more. If the range is good, it moves one element pair per clock through a single read port and a single write port of the register file. When no pair is left, it pulses `done_o`. The masks are made somewhere else, and no arithmetic is done on the data.

Top module: `tpm_move_unit`

## Requirements
- R1: With both sides vector, the k-th set bit of the source mask (counted from bit 0 upward) sends register `src_base+i` to register `dst_base+j`, where j is the k-th set bit of the destination mask.
- R2: Pairs are moved in rising element order. The number of writes equals the smaller of the two enabled counts. Destination slots that are enabled but left over keep their old contents.
- R3: A scalar source is active only when source mask bit 0 is set. Every move then reads register `src_base`, so a one-hot destination mask writes that value into exactly one destination slot. When bit 0 is clear, there are no writes.
- R4: A scalar destination is active only when destination mask bit 0 is set. Every move then writes register `dst_base`, so after the operation that register holds the last enabled source element.
- R5: When both sides are scalar and both masks have bit 0 set, exactly one move is made: `src_base` is copied to `dst_base`.
- R6: A trap is raised when VL exceeds MAXVL (8 by default), or when a vector side has base+VL greater than the register count (32). The trap is a one-cycle `trap_o` in the cycle after start, with no write and no `done_o`. A scalar side never traps because of its base, and base+VL equal to 32 is legal.
- R7: Mask bits at element positions VL or above are ignored and cause no trap.
- R8: One pair is written per clock, starting in the cycle after start. `done_o` is high for exactly one cycle, in the cycle after the last write. With zero pairs it is high in the cycle after start.
- R9: A start pulse while the unit is busy is ignored. The running operation finishes with its own parameters.
- R10: After reset, `busy_o`, `done_o`, `trap_o` and `rf_we_o` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, taken only while idle |
| src_base_i | input | 5 | Source base register |
| dst_base_i | input | 5 | Destination base register |
| vl_i | input | 4 | Vector length, 0 to MAXVL |
| src_mask_i | input | 8 | Source predicate, bit i = element i |
| dst_mask_i | input | 8 | Destination predicate, bit i = element i |
| src_scalar_i | input | 1 | Source is scalar |
| dst_scalar_i | input | 1 | Destination is scalar |
| rf_raddr_o | output | 5 | Register-file read address |
| rf_rdata_i | input | 64 | Register-file read data, combinational |
| rf_we_o | output | 1 | Register-file write enable |
| rf_waddr_o | output | 5 | Register-file write address |
| rf_wdata_o | output | 64 | Register-file write data |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| trap_o | output | 1 | One-cycle range-violation pulse |

## Verification
The mask copies held by the unit shrink by one bit per move. A bit cleared wrongly, or one left set, shows in the same cycle as a write to the wrong slot or a read of the wrong element. It also shifts the cycle in which `done_o` rises by at least one, so the cycle position of `done_o` and the final register contents are compared against an arithmetic model after every operation. A wrong latch of the scalar flags or the bases shows on the first write address. A wrong range decision shows one cycle after start, as a trap where a done was due, or the reverse.

// File: rtl/tpm_pkg.sv
package tpm_pkg;

    typedef enum logic {
        S_IDLE = 1'b0,
        S_MOVE = 1'b1
    } tpm_state_e;

endpackage

// File: rtl/tpm_issue_check.sv
// Issue-time range check and trimming of both masks to the vector length.
module tpm_issue_check #(
    parameter int NREG  = 32,
    parameter int MAXVL = 8,
    localparam int RW   = $clog2(NREG),
    localparam int VLW  = $clog2(MAXVL + 1)
) (
    input  logic [RW-1:0]    src_base,
    input  logic [RW-1:0]    dst_base,
    input  logic [VLW-1:0]   vl,
    input  logic             src_scalar,
    input  logic             dst_scalar,
    input  logic [MAXVL-1:0] src_mask,
    input  logic [MAXVL-1:0] dst_mask,
    output logic             trap,
    output logic [MAXVL-1:0] src_mask_trim,
    output logic [MAXVL-1:0] dst_mask_trim
);
    localparam int SW = ((RW > VLW) ? RW : VLW) + 1;

    logic [SW-1:0] src_end, dst_end;
    logic          vl_bad, src_over, dst_over;

    assign src_end  = SW'(src_base) + SW'(vl);
    assign dst_end  = SW'(dst_base) + SW'(vl);
    assign vl_bad   = vl > VLW'(MAXVL);
    assign src_over = !src_scalar && (src_end > SW'(NREG));
    assign dst_over = !dst_scalar && (dst_end > SW'(NREG));
    assign trap     = vl_bad || src_over || dst_over;

    for (genvar g = 0; g < MAXVL; g++) begin : g_trim
        assign src_mask_trim[g] = src_mask[g] && (VLW'(g) < vl);
        assign dst_mask_trim[g] = dst_mask[g] && (VLW'(g) < vl);
    end
endmodule

// File: rtl/tpm_lowest_set.sv
// Finds the lowest set bit of a mask.
module tpm_lowest_set #(
    parameter int W  = 8,
    localparam int IW = $clog2(W)
) (
    input  logic [W-1:0]  mask,
    output logic          found,
    output logic [IW-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (mask[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/tpm_elem_addr.sv
// Register number of one element: the base alone for a scalar side.
module tpm_elem_addr #(
    parameter int RW = 5,
    parameter int IW = 3
) (
    input  logic [RW-1:0] base,
    input  logic [IW-1:0] idx,
    input  logic          scalar,
    output logic [RW-1:0] addr
);
    assign addr = scalar ? base : (base + RW'(idx));
endmodule

// File: rtl/tpm_move_unit.sv
// Element-pairing sequencer for the twin-predicated move.
module tpm_move_unit
    import tpm_pkg::*;
#(
    parameter int NREG  = 32,
    parameter int XLEN  = 64,
    parameter int MAXVL = 8,
    localparam int RW   = $clog2(NREG),
    localparam int VLW  = $clog2(MAXVL + 1),
    localparam int IW   = $clog2(MAXVL)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [RW-1:0]    src_base_i,
    input  logic [RW-1:0]    dst_base_i,
    input  logic [VLW-1:0]   vl_i,
    input  logic [MAXVL-1:0] src_mask_i,
    input  logic [MAXVL-1:0] dst_mask_i,
    input  logic             src_scalar_i,
    input  logic             dst_scalar_i,
    output logic [RW-1:0]    rf_raddr_o,
    input  logic [XLEN-1:0]  rf_rdata_i,
    output logic             rf_we_o,
    output logic [RW-1:0]    rf_waddr_o,
    output logic [XLEN-1:0]  rf_wdata_o,
    output logic             busy_o,
    output logic             done_o,
    output logic             trap_o
);
    localparam int SW = ((RW > VLW) ? RW : VLW) + 1;

    typedef struct packed {
        tpm_state_e       state;
        logic [RW-1:0]    src_base;
        logic [RW-1:0]    dst_base;
        logic [VLW-1:0]   vl;
        logic [MAXVL-1:0] src_mask;
        logic [MAXVL-1:0] dst_mask;
        logic             src_sc;
        logic             dst_sc;
        logic             trap;
    } regs_t;

    localparam regs_t REGS_RST = '{
        state:    S_IDLE,
        src_base: '0,
        dst_base: '0,
        vl:       '0,
        src_mask: '0,
        dst_mask: '0,
        src_sc:   1'b0,
        dst_sc:   1'b0,
        trap:     1'b0
    };

    regs_t r_d, r_q;

    logic             chk_trap;
    logic [MAXVL-1:0] src_trim, dst_trim;
    logic             s_found, d_found;
    logic [IW-1:0]    s_idx, d_idx;
    logic             src_avail, dst_avail, pair, finish;
    logic [RW-1:0]    src_addr, dst_addr;

    tpm_issue_check #(.NREG(NREG), .MAXVL(MAXVL)) u_check (
        .src_base      (src_base_i),
        .dst_base      (dst_base_i),
        .vl            (vl_i),
        .src_scalar    (src_scalar_i),
        .dst_scalar    (dst_scalar_i),
        .src_mask      (src_mask_i),
        .dst_mask      (dst_mask_i),
        .trap          (chk_trap),
        .src_mask_trim (src_trim),
        .dst_mask_trim (dst_trim)
    );

    tpm_lowest_set #(.W(MAXVL)) u_src_find (
        .mask  (r_q.src_mask),
        .found (s_found),
        .idx   (s_idx)
    );

    tpm_lowest_set #(.W(MAXVL)) u_dst_find (
        .mask  (r_q.dst_mask),
        .found (d_found),
        .idx   (d_idx)
    );

    tpm_elem_addr #(.RW(RW), .IW(IW)) u_src_addr (
        .base   (r_q.src_base),
        .idx    (s_idx),
        .scalar (r_q.src_sc),
        .addr   (src_addr)
    );

    tpm_elem_addr #(.RW(RW), .IW(IW)) u_dst_addr (
        .base   (r_q.dst_base),
        .idx    (d_idx),
        .scalar (r_q.dst_sc),
        .addr   (dst_addr)
    );

    // A scalar side is live while bit 0 of its trimmed mask stays set.
    assign src_avail = r_q.src_sc ? r_q.src_mask[0] : s_found;
    assign dst_avail = r_q.dst_sc ? r_q.dst_mask[0] : d_found;
    assign pair      = (r_q.state == S_MOVE) && src_avail && dst_avail;
    assign finish    = (r_q.state == S_MOVE) && !pair;

    always_comb begin
        r_d      = r_q;
        r_d.trap = 1'b0;
        unique case (r_q.state)
            S_IDLE: begin
                if (start_i) begin
                    if (chk_trap) begin
                        r_d.trap = 1'b1;
                    end else begin
                        r_d.state    = S_MOVE;
                        r_d.src_base = src_base_i;
                        r_d.dst_base = dst_base_i;
                        r_d.vl       = vl_i;
                        r_d.src_mask = src_trim;
                        r_d.dst_mask = dst_trim;
                        r_d.src_sc   = src_scalar_i;
                        r_d.dst_sc   = dst_scalar_i;
                    end
                end
            end
            S_MOVE: begin
                if (pair) begin
                    if (r_q.src_sc && r_q.dst_sc) begin
                        r_d.src_mask = '0;
                        r_d.dst_mask = '0;
                    end else begin
                        if (!r_q.src_sc) r_d.src_mask[s_idx] = 1'b0;
                        if (!r_q.dst_sc) r_d.dst_mask[d_idx] = 1'b0;
                    end
                end else begin
                    r_d.state = S_IDLE;
                end
            end
            default: r_d.state = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= REGS_RST;
        else        r_q <= r_d;
    end

    assign rf_raddr_o = src_addr;
    assign rf_we_o    = pair;
    assign rf_waddr_o = dst_addr;
    assign rf_wdata_o = rf_rdata_i;
    assign busy_o     = (r_q.state == S_MOVE);
    assign done_o     = finish;
    assign trap_o     = r_q.trap;

    // R8: completion is a single-cycle pulse
    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R6: a trap comes with no write and no running operation
    a_r6_trap_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        trap_o |-> (!rf_we_o && !busy_o && !done_o));

    // R2: back-to-back writes on a vector destination climb in register number
    a_r2_dst_ascending: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_we_o && $past(rf_we_o) && !r_q.dst_sc) |-> (rf_waddr_o > $past(rf_waddr_o)));

    // R2: back-to-back reads on a vector source climb in register number
    a_r2_src_ascending: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_we_o && $past(rf_we_o) && !r_q.src_sc) |-> (rf_raddr_o > $past(rf_raddr_o)));

    // R6: no vector-side write leaves the checked range
    a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_we_o && !r_q.dst_sc) |->
            ((SW'(rf_waddr_o) < (SW'(r_q.dst_base) + SW'(r_q.vl))) && (rf_waddr_o >= r_q.dst_base)));

    // R9: operation parameters do not change while busy
    a_r9_hold_params: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> ($stable(r_q.src_base) && $stable(r_q.dst_base) && $stable(r_q.vl)));

    // R8: no write in the done cycle
    a_r8_done_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !rf_we_o);
endmodule

// File: tb/tb_tpm_move_unit.sv
`timescale 1ns/1ps
module tb_tpm_move_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [4:0]  src_base_i = '0, dst_base_i = '0;
    logic [3:0]  vl_i = '0;
    logic [7:0]  src_mask_i = '0, dst_mask_i = '0;
    logic        src_scalar_i = 1'b0, dst_scalar_i = 1'b0;
    logic [4:0]  rf_raddr_o, rf_waddr_o;
    logic [63:0] rf_rdata_i, rf_wdata_o;
    logic        rf_we_o, busy_o, done_o, trap_o;

    logic [63:0] rf     [32];
    logic [63:0] exp_rf [32];

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    logic [31:0] seed = 32'h1234_5678;

    always #2 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (rf_we_o) rf[rf_waddr_o] <= rf_wdata_o;
    end

    assign rf_rdata_i = rf[rf_raddr_o];

    tpm_move_unit dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .src_base_i(src_base_i), .dst_base_i(dst_base_i), .vl_i(vl_i),
        .src_mask_i(src_mask_i), .dst_mask_i(dst_mask_i),
        .src_scalar_i(src_scalar_i), .dst_scalar_i(dst_scalar_i),
        .rf_raddr_o(rf_raddr_o), .rf_rdata_i(rf_rdata_i),
        .rf_we_o(rf_we_o), .rf_waddr_o(rf_waddr_o), .rf_wdata_o(rf_wdata_o),
        .busy_o(busy_o), .done_o(done_o), .trap_o(trap_o)
    );

    function automatic logic [31:0] rnd();
        seed = seed ^ (seed << 13);
        seed = seed ^ (seed >> 17);
        seed = seed ^ (seed << 5);
        return seed;
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Reference model from the requirements; returns trap flag and move count.
    task automatic model(input int sb, input int db, input int vl, input logic [7:0] sm,
                         input logic [7:0] dm, input bit ss, input bit ds,
                         output bit etrap, output int n);
        logic [7:0] lowm, ms, md;
        int sp, dp, s, d;
        n = 0;
        etrap = (vl > 8) || (!ss && (sb + vl > 32)) || (!ds && (db + vl > 32));
        if (etrap) return;
        lowm = (vl >= 8) ? 8'hFF : 8'((1 << vl) - 1);
        ms = sm & lowm;
        md = dm & lowm;
        if (ss && ds) begin
            if (ms[0] && md[0]) begin
                exp_rf[db] = exp_rf[sb];
                n = 1;
            end
            return;
        end
        sp = 0;
        dp = 0;
        forever begin
            s = -1;
            d = -1;
            if (ss) s = ms[0] ? 0 : -1;
            else for (int i = 7; i >= sp; i--) if (ms[i]) s = i;
            if (ds) d = md[0] ? 0 : -1;
            else for (int i = 7; i >= dp; i--) if (md[i]) d = i;
            if (s < 0 || d < 0) break;
            exp_rf[ds ? db : db + d] = exp_rf[ss ? sb : sb + s];
            n++;
            if (!ss) sp = s + 1;
            if (!ds) dp = d + 1;
        end
    endtask

    task automatic run_op(input int sb, input int db, input int vl, input logic [7:0] sm,
                          input logic [7:0] dm, input bit ss, input bit ds,
                          input string tag, input bit poke);
        bit etrap, seen_done, seen_trap, rf_ok;
        int n, k, wn;
        @(negedge clk);
        for (int i = 0; i < 32; i++) begin
            rf[i]     = {rnd(), rnd()};
            exp_rf[i] = rf[i];
        end
        model(sb, db, vl, sm, dm, ss, ds, etrap, n);
        src_base_i = 5'(sb); dst_base_i = 5'(db); vl_i = 4'(vl);
        src_mask_i = sm; dst_mask_i = dm;
        src_scalar_i = ss; dst_scalar_i = ds;
        start_i = 1'b1;
        k = 0; wn = 0; seen_done = 0; seen_trap = 0;
        while (k < 40) begin
            @(negedge clk);
            k++;
            if (rf_we_o) wn++;
            seen_done = done_o;
            seen_trap = trap_o;
            if (poke && k == 1) begin
                src_base_i = 5'd0; dst_base_i = 5'd0; vl_i = 4'd8;
                src_mask_i = 8'hFF; dst_mask_i = 8'hFF;
                src_scalar_i = 1'b0; dst_scalar_i = 1'b0;
                start_i = 1'b1;
            end else begin
                start_i = 1'b0;
            end
            if (seen_done || seen_trap) break;
        end
        start_i = 1'b0;
        if (etrap) begin
            check(seen_trap && k == 1, tag, "trap cycle", 64'(k), 64'd1);
        end else begin
            check(seen_done && !seen_trap && k == n + 1, tag, "done cycle", 64'(k), 64'(n + 1));
        end
        check(wn == n, tag, "write count", 64'(wn), 64'(n));
        rf_ok = 1'b1;
        for (int i = 0; i < 32; i++) if (rf[i] !== exp_rf[i]) rf_ok = 1'b0;
        for (int i = 0; i < 32; i++)
            if (rf[i] !== exp_rf[i]) check(1'b0, tag, $sformatf("reg %0d", i), rf[i], exp_rf[i]);
        if (rf_ok) check(1'b1, tag, "register file", '0, '0);
    endtask

    initial begin : watchdog
        wait (cyc > 150000);
        errors++;
        $display("FAIL watchdog actual=%0d expected<150000", cyc);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: quiet outputs after reset
        check(!busy_o && !done_o && !trap_o && !rf_we_o, "R10", "reset outputs",
              {60'd0, busy_o, done_o, trap_o, rf_we_o}, 64'd0);

        run_op(0, 16, 8, 8'b1011_0101, 8'b1110_1011, 0, 0, "R1", 0);
        run_op(3, 20, 7, 8'b0101_1010, 8'b0011_1100, 0, 0, "R1", 0);
        run_op(2, 10, 8, 8'b0000_0110, 8'hFF, 0, 0, "R2", 0);
        run_op(2, 10, 8, 8'hFF, 8'b1000_0001, 0, 0, "R2", 0);
        run_op(4, 5, 8, 8'hFF, 8'hFF, 0, 0, "R2", 0);
        run_op(9, 12, 8, 8'h01, 8'b0001_0000, 1, 0, "R3", 0);
        run_op(9, 12, 8, 8'hFE, 8'hFF, 1, 0, "R3", 0);
        run_op(6, 30, 6, 8'b0010_1101, 8'h01, 0, 1, "R4", 0);
        run_op(7, 8, 3, 8'h01, 8'h01, 1, 1, "R5", 0);
        run_op(7, 8, 3, 8'h01, 8'h00, 1, 1, "R5", 0);
        run_op(24, 0, 8, 8'hFF, 8'hFF, 0, 0, "R6", 0);
        run_op(25, 0, 8, 8'hFF, 8'hFF, 0, 0, "R6", 0);
        run_op(0, 31, 2, 8'hFF, 8'hFF, 0, 0, "R6", 0);
        run_op(0, 0, 9, 8'hFF, 8'hFF, 0, 0, "R6", 0);
        run_op(0, 31, 8, 8'hFF, 8'h01, 0, 1, "R6", 0);
        run_op(1, 20, 3, 8'hFF, 8'hFF, 0, 0, "R7", 0);
        run_op(29, 29, 3, 8'hF8, 8'hF8, 0, 0, "R7", 0);
        run_op(5, 15, 0, 8'hFF, 8'hFF, 0, 0, "R8", 0);
        run_op(5, 15, 8, 8'hFF, 8'h00, 0, 0, "R8", 0);
        run_op(16, 24, 8, 8'b0111_0111, 8'b1101_1110, 0, 0, "R9", 1);

        for (int t = 0; t < 1500; t++) begin
            int vl, sb, db;
            bit ss, ds;
            logic [7:0] sm, dm;
            string tag;
            vl = int'(rnd() % 10);
            ss = (rnd() % 4) == 0;
            ds = (rnd() % 4) == 0;
            sb = ((rnd() % 4) == 0 || vl > 8) ? int'(rnd() % 32) : int'(rnd() % (33 - vl));
            db = ((rnd() % 4) == 0 || vl > 8) ? int'(rnd() % 32) : int'(rnd() % (33 - vl));
            sm = 8'(rnd());
            dm = 8'(rnd());
            if (ss && (rnd() % 2) == 0) sm[0] = 1'b1;
            if (ds && (rnd() % 2) == 0) dm[0] = 1'b1;
            if ((vl > 8) || (!ss && sb + vl > 32) || (!ds && db + vl > 32)) tag = "R6";
            else if (ss && ds) tag = "R5";
            else if (ss) tag = "R3";
            else if (ds) tag = "R4";
            else tag = "R1";
            run_op(sb, db, vl, sm, dm, ss, ds, tag, 0);
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule